// File: doc/BRIEF.md
# Indirect Configuration Access Port Translator

This block sits on a host I/O port bus with a 16-bit byte address, 32-bit data, four byte lanes and a read/write flag. It turns two well-known I/O ports into a path to configuration space. A full 32-bit write to the address port (0CF8h) loads a selector. The selector holds an enable bit, a bus number, a device number, a function number and a dword register index. Host accesses to the data port (0CFCh–0CFFh) then become configuration read or write requests toward a downstream configuration master. Every other host access goes out unchanged on a pass-through I/O port.

A request whose bus number matches the local bus number pin is a local (type 0) cycle. Its low address bits are zero, and the target is picked by a one-hot device-select vector. Any other bus number gives a remote (type 1) cycle, which carries the whole selector on the address lines. If the enable bit is clear, the data port reads as all ones and drops writes.

The host side and both downstream request sides use valid/ready. The host holds a request, with every field stable, until `h_ready` is high. `h_ready` is high for one cycle per access, and it is only high after the whole access has finished. For reads, `h_rvalid` and `h_rdata` are valid in that same cycle. The downstream master and the pass-through port hold their request fields while `*_valid` is high and `*_ready` is low. They then signal completion with a one-cycle `*_done` pulse, carrying read data, no earlier than the cycle after the handshake.

Top module: `cfg_port_xlate`

## Requirements
- R1: After reset the selector is all zero, and `h_ready`, `h_rvalid`, `c_valid` and `p_valid` are low until a host request arrives.
- R2: A write to address 0CF8h with byte enables 1111b stores these fields: enable from bit 31, bus from bits 23:16, device from bits 15:11, function from bits 10:8 and register index from bits 7:2. A read there returns those fields in the same positions, with bits 30:24 and 1:0 read as zero.
- R3: An access to 0CF8h whose byte enables are not 1111b leaves the selector unchanged and is forwarded on the pass-through port.
- R4: While the enable bit is 0, a read of 0CFCh–0CFFh returns FFFFFFFFh, a write there is discarded, and no configuration request is issued.
- R5: With enable 1 and the bus field equal to `local_bus`, the request has `c_type`=0 and `c_addr` = {21'b0, function, register, 2'b00}. `c_idsel` has exactly bit <device> set.
- R6: With enable 1 and the bus field different from `local_bus`, the request has `c_type`=1 and `c_addr` = {8'h00, bus, device, function, register, 2'b01}. `c_idsel` is all zero.
- R7: A configuration request carries the host byte enables, write data and direction unchanged, including byte- and word-wide accesses at 0CFDh–0CFFh.
- R8: A configuration read completes to the host only after `c_done`. `h_ready` and `h_rvalid` rise in the cycle after `c_done`, with `h_rdata` equal to the `c_rdata` sampled alongside it. `h_rvalid` is never high for writes.
- R9: Any other address is forwarded on the pass-through port with address, byte enables, data and direction unchanged. A pass-through read returns `p_rdata`. The request holds steady until `p_ready`.
- R10: Each configuration access issues exactly one downstream request, and it holds steady until `c_ready`.
- R11: A selector write takes effect for the very next host access, even when that access starts in the cycle right after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_bus | input | 8 | Bus number treated as local (type 0) |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request accepted and completed |
| h_write | input | 1 | Host direction, 1 = write |
| h_addr | input | 16 | Host I/O byte address |
| h_be | input | 4 | Host byte lane enables |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Read data valid (with h_ready) |
| h_rdata | output | 32 | Read data to host |
| p_valid | output | 1 | Pass-through request valid |
| p_ready | input | 1 | Pass-through request accepted |
| p_write | output | 1 | Pass-through direction |
| p_addr | output | 16 | Pass-through address |
| p_be | output | 4 | Pass-through byte enables |
| p_wdata | output | 32 | Pass-through write data |
| p_done | input | 1 | Pass-through completion pulse |
| p_rdata | input | 32 | Pass-through read data |
| c_valid | output | 1 | Configuration request valid |
| c_ready | input | 1 | Configuration request accepted |
| c_write | output | 1 | Configuration direction |
| c_type | output | 1 | 0 = local cycle, 1 = remote cycle |
| c_bus | output | 8 | Bus number |
| c_dev | output | 5 | Device number |
| c_func | output | 3 | Function number |
| c_reg | output | 6 | Dword register index |
| c_be | output | 4 | Byte enables |
| c_wdata | output | 32 | Configuration write data |
| c_addr | output | 32 | Address word for the cycle type |
| c_idsel | output | NDEV | One-hot device select for local cycles |
| c_done | input | 1 | Configuration completion pulse |
| c_rdata | input | 32 | Configuration read data |

## Verification
Two functions can meet in one cycle. A selector write to 0CF8h is applied in the cycle the host is released. A data-port access from the host can be sampled at the very next edge. The bench drives requests back to back with no idle cycle, so a new selector is always followed at once by a data-port access. It then checks that the downstream cycle type, `c_addr` and `c_idsel` already follow the new fields. The bench also changes `local_bus` just before such accesses, and it computes the expected type from the value in force when the access is sampled.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned DEV_W  = 5;
  localparam int unsigned FUNC_W = 3;
  localparam int unsigned REG_W  = 6;

  typedef enum logic [1:0] {
    K_PASS = 2'd0,
    K_AREG = 2'd1,
    K_DOFF = 2'd2,
    K_CFG  = 2'd3
  } acc_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CISS  = 3'd1,
    ST_CWAIT = 3'd2,
    ST_PISS  = 3'd3,
    ST_PWAIT = 3'd4,
    ST_DONE  = 3'd5
  } seq_st_t;

  typedef struct packed {
    logic              en;
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic [REG_W-1:0]  regno;
  } cfg_sel_t;
endpackage

// File: rtl/cfg_sel_reg.sv
module cfg_sel_reg
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  cfg_sel_t      wr_val,
  output cfg_sel_t      sel,
  output logic [DW-1:0] rdback
);
  cfg_sel_t sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wr_val;
  end

  assign sel = sel_q;
  // Reserved and type bits always read back as zero.
  assign rdback = {sel_q.en, 7'b0, sel_q.bus, sel_q.dev, sel_q.func, sel_q.regno, 2'b00};
endmodule

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned    AW        = 16,
  parameter logic [AW-1:0]  ADDR_PORT = 16'h0CF8,
  parameter logic [AW-1:0]  DATA_PORT = 16'h0CFC
) (
  input  logic [AW-1:0] addr,
  input  logic [3:0]    be,
  input  logic          en,
  output acc_kind_t     kind
);
  logic hit_areg, hit_data;

  assign hit_areg = (addr == ADDR_PORT) && (be == 4'hF);
  assign hit_data = (addr[AW-1:2] == DATA_PORT[AW-1:2]);

  always_comb begin
    if (hit_areg)      kind = K_AREG;
    else if (hit_data) kind = en ? K_CFG : K_DOFF;
    else               kind = K_PASS;
  end
endmodule

// File: rtl/cfg_cycle_build.sv
module cfg_cycle_build
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned NDEV = 32
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FUNC_W-1:0] func,
  input  logic [REG_W-1:0]  regno,
  input  logic [BUS_W-1:0]  local_bus,
  output logic              ctype,
  output logic [31:0]       caddr,
  output logic [NDEV-1:0]   idsel
);
  localparam int unsigned PAD0 = 32 - FUNC_W - REG_W - 2;

  assign ctype = (bus != local_bus);
  assign caddr = ctype ? {8'h00, bus, dev, func, regno, 2'b01}
                       : {{PAD0{1'b0}}, func, regno, 2'b00};

  for (genvar g = 0; g < NDEV; g++) begin : g_sel
    assign idsel[g] = !ctype && (dev == DEV_W'(g));
  end
endmodule

// File: rtl/cfg_port_xlate.sv
module cfg_port_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter int unsigned   NDEV      = 32,
  parameter logic [AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [AW-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       local_bus,
  input  logic             h_valid,
  output logic             h_ready,
  input  logic             h_write,
  input  logic [AW-1:0]    h_addr,
  input  logic [3:0]       h_be,
  input  logic [31:0]      h_wdata,
  output logic             h_rvalid,
  output logic [31:0]      h_rdata,
  output logic             p_valid,
  input  logic             p_ready,
  output logic             p_write,
  output logic [AW-1:0]    p_addr,
  output logic [3:0]       p_be,
  output logic [31:0]      p_wdata,
  input  logic             p_done,
  input  logic [31:0]      p_rdata,
  output logic             c_valid,
  input  logic             c_ready,
  output logic             c_write,
  output logic             c_type,
  output logic [7:0]       c_bus,
  output logic [4:0]       c_dev,
  output logic [2:0]       c_func,
  output logic [5:0]       c_reg,
  output logic [3:0]       c_be,
  output logic [31:0]      c_wdata,
  output logic [31:0]      c_addr,
  output logic [NDEV-1:0]  c_idsel,
  input  logic             c_done,
  input  logic [31:0]      c_rdata
);
  localparam int unsigned DW = 32;

  seq_st_t   st_q;
  acc_kind_t kind_q, kind_now;
  logic [DW-1:0] rsp_q;
  cfg_sel_t  cur_sel, new_sel;
  logic [DW-1:0] sel_rd;
  logic      sel_wr;
  logic      cfg_en;

  assign new_sel = '{en:    h_wdata[31],
                     bus:   h_wdata[23:16],
                     dev:   h_wdata[15:11],
                     func:  h_wdata[10:8],
                     regno: h_wdata[7:2]};
  assign sel_wr  = (st_q == ST_DONE) && (kind_q == K_AREG) && h_write;
  assign cfg_en  = cur_sel.en;

  cfg_sel_reg #(.DW(DW)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(sel_wr), .wr_val(new_sel),
    .sel(cur_sel), .rdback(sel_rd)
  );

  cfg_port_decode #(.AW(AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_dec (
    .addr(h_addr), .be(h_be), .en(cur_sel.en), .kind(kind_now)
  );

  cfg_cycle_build #(.NDEV(NDEV)) u_bld (
    .bus(cur_sel.bus), .dev(cur_sel.dev), .func(cur_sel.func), .regno(cur_sel.regno),
    .local_bus(local_bus), .ctype(c_type), .caddr(c_addr), .idsel(c_idsel)
  );

  // Access sequencer: one host access at a time, released in ST_DONE.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_PASS;
      rsp_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (h_valid) begin
          kind_q <= kind_now;
          unique case (kind_now)
            K_AREG: begin rsp_q <= sel_rd; st_q <= ST_DONE; end
            K_DOFF: begin rsp_q <= '1;     st_q <= ST_DONE; end
            K_CFG:  st_q <= ST_CISS;
            default: st_q <= ST_PISS;
          endcase
        end
        ST_CISS:  if (c_ready) st_q <= ST_CWAIT;
        ST_CWAIT: if (c_done) begin rsp_q <= c_rdata; st_q <= ST_DONE; end
        ST_PISS:  if (p_ready) st_q <= ST_PWAIT;
        ST_PWAIT: if (p_done) begin rsp_q <= p_rdata; st_q <= ST_DONE; end
        ST_DONE:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign h_ready  = (st_q == ST_DONE);
  assign h_rvalid = h_ready && !h_write;
  assign h_rdata  = h_rvalid ? rsp_q : '0;

  assign c_valid  = (st_q == ST_CISS);
  assign c_write  = h_write;
  assign c_be     = h_be;
  assign c_wdata  = h_wdata;
  assign c_bus    = cur_sel.bus;
  assign c_dev    = cur_sel.dev;
  assign c_func   = cur_sel.func;
  assign c_reg    = cur_sel.regno;

  assign p_valid  = (st_q == ST_PISS);
  assign p_write  = h_write;
  assign p_addr   = h_addr;
  assign p_be     = h_be;
  assign p_wdata  = h_wdata;
endmodule

// File: rtl/cfg_port_xlate_chk.sv
module cfg_port_xlate_chk #(
  parameter int unsigned AW   = 16,
  parameter int unsigned NDEV = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            h_ready,
  input logic            h_write,
  input logic            h_rvalid,
  input logic            c_valid,
  input logic            c_ready,
  input logic            c_type,
  input logic [31:0]     c_addr,
  input logic [NDEV-1:0] c_idsel,
  input logic [3:0]      c_be,
  input logic [31:0]     c_wdata,
  input logic            p_valid,
  input logic            p_ready,
  input logic [AW-1:0]   p_addr,
  input logic            cfg_en
);
  a_r10_creq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid && !c_ready |=> c_valid && $stable(c_addr) && $stable(c_be) && $stable(c_wdata));

  a_r9_preq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid && !p_ready |=> p_valid && $stable(p_addr));

  a_r4_cfg_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> cfg_en);

  a_r5_local_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid && !c_type |-> ($countones(c_idsel) == 1) && (c_addr[1:0] == 2'b00));

  a_r6_remote_nosel: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid && c_type |-> (c_idsel == '0) && (c_addr[1:0] == 2'b01));

  a_r8_rvalid_accept: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid |-> h_ready && !h_write);

  a_r8_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready |-> !c_valid && !p_valid);

  a_r3_single_path: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_valid && p_valid));
endmodule

bind cfg_port_xlate cfg_port_xlate_chk #(.AW(AW), .NDEV(NDEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_ready(h_ready), .h_write(h_write), .h_rvalid(h_rvalid),
  .c_valid(c_valid), .c_ready(c_ready), .c_type(c_type), .c_addr(c_addr),
  .c_idsel(c_idsel), .c_be(c_be), .c_wdata(c_wdata), .p_valid(p_valid),
  .p_ready(p_ready), .p_addr(p_addr), .cfg_en(cfg_en)
);

// File: tb/test_cfg_port_xlate.sv
module test_cfg_port_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  local_bus = 8'h00;
  logic        h_valid = 1'b0, h_write = 1'b0;
  logic [15:0] h_addr = '0;
  logic [3:0]  h_be = '0;
  logic [31:0] h_wdata = '0;
  logic        h_ready, h_rvalid;
  logic [31:0] h_rdata;
  logic        p_valid, p_write, p_ready = 1'b0, p_done = 1'b0;
  logic [15:0] p_addr;
  logic [3:0]  p_be;
  logic [31:0] p_wdata, p_rdata = '0;
  logic        c_valid, c_write, c_type, c_ready = 1'b0, c_done = 1'b0;
  logic [7:0]  c_bus;
  logic [4:0]  c_dev;
  logic [2:0]  c_func;
  logic [5:0]  c_reg;
  logic [3:0]  c_be;
  logic [31:0] c_wdata, c_addr, c_rdata = '0;
  logic [31:0] c_idsel;

  cfg_port_xlate i_cfg_port_xlate (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int c_acc = 0, p_acc = 0;
  bit c_done_seen = 0;
  logic [31:0] last_c_rd, last_p_rd;
  // bench model of the selector
  bit sh_en; logic [7:0] sh_bus; logic [4:0] sh_dev; logic [2:0] sh_func; logic [5:0] sh_reg;
  // expectations for downstream sides
  bit exp_cfg, exp_pass;
  logic exp_type, exp_write; logic [31:0] exp_caddr, exp_idsel, exp_wdata; logic [3:0] exp_be;
  logic [15:0] exp_paddr;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sel_read();
    return {sh_en, 7'b0, sh_bus, sh_dev, sh_func, sh_reg, 2'b00};
  endfunction

  function automatic int kind_of(input logic [15:0] a, input logic [3:0] be);
    if (a == 16'h0CF8 && be == 4'hF) return 1;
    if (a[15:2] == 14'h033F) return sh_en ? 3 : 2;
    return 0;
  endfunction

  // configuration master model
  initial begin
    forever begin
      @(negedge clk);
      c_ready = 1'b0; c_done = 1'b0;
      if (c_valid && ($urandom % 3 != 0)) begin
        c_ready = 1'b1;
        c_acc++;
        chk(exp_cfg, "R4 unexpected config request", {31'b0, c_valid}, 32'h0);
        chk(c_type == exp_type, exp_type ? "R6 type" : "R5 type", {31'b0, c_type}, {31'b0, exp_type});
        chk(c_addr == exp_caddr, exp_type ? "R6 addr" : "R5 addr", c_addr, exp_caddr);
        chk(c_idsel == exp_idsel, exp_type ? "R6 idsel" : "R5 idsel", c_idsel, exp_idsel);
        chk(c_be == exp_be && c_write == exp_write, "R7 be/dir", {27'b0, c_write, c_be}, {27'b0, exp_write, exp_be});
        chk(c_wdata == exp_wdata, "R7 wdata", c_wdata, exp_wdata);
        @(negedge clk);
        c_ready = 1'b0;
        repeat ($urandom % 4) @(negedge clk);
        c_rdata = $urandom;
        last_c_rd = c_rdata;
        c_done_seen = 1'b1;
        c_done = 1'b1;
      end
    end
  end

  // pass-through port model
  initial begin
    forever begin
      @(negedge clk);
      p_ready = 1'b0; p_done = 1'b0;
      if (p_valid && ($urandom % 3 != 0)) begin
        p_ready = 1'b1;
        p_acc++;
        chk(exp_pass, "R9 unexpected pass request", {31'b0, p_valid}, 32'h0);
        chk(p_addr == exp_paddr, "R9 addr", {16'b0, p_addr}, {16'b0, exp_paddr});
        chk(p_be == exp_be && p_write == exp_write, "R9 be/dir", {27'b0, p_write, p_be}, {27'b0, exp_write, exp_be});
        chk(p_wdata == exp_wdata, "R9 wdata", p_wdata, exp_wdata);
        @(negedge clk);
        p_ready = 1'b0;
        repeat ($urandom % 4) @(negedge clk);
        p_rdata = $urandom;
        last_p_rd = p_rdata;
        p_done = 1'b1;
      end
    end
  end

  task automatic access(input bit wr, input logic [15:0] a, input logic [3:0] be, input logic [31:0] wd);
    int k = kind_of(a, be);
    int c0 = c_acc, p0 = p_acc;
    int waited = 0;
    exp_cfg = (k == 3); exp_pass = (k == 0);
    exp_write = wr; exp_be = be; exp_wdata = wd; exp_paddr = a;
    exp_type  = (sh_bus != local_bus);
    exp_caddr = exp_type ? {8'h00, sh_bus, sh_dev, sh_func, sh_reg, 2'b01}
                         : {21'b0, sh_func, sh_reg, 2'b00};
    exp_idsel = exp_type ? 32'h0 : (32'h1 << sh_dev);
    c_done_seen = 1'b0;
    @(negedge clk);
    h_valid = 1'b1; h_write = wr; h_addr = a; h_be = be; h_wdata = wd;
    do begin
      @(negedge clk);
      waited++;
    end while (!h_ready && waited < 200);
    chk(h_ready, "R8 host release", {31'b0, h_ready}, 32'h1);
    chk(h_rvalid == !wr, "R8 rvalid", {31'b0, h_rvalid}, {31'b0, !wr});
    case (k)
      1: begin
        chk(c_acc == c0 && p_acc == p0, "R2 no downstream", c_acc - c0 + p_acc - p0, 0);
        if (!wr) chk(h_rdata == sel_read(), "R2 readback", h_rdata, sel_read());
        else begin
          sh_en = wd[31]; sh_bus = wd[23:16]; sh_dev = wd[15:11]; sh_func = wd[10:8]; sh_reg = wd[7:2];
        end
      end
      2: begin
        chk(c_acc == c0 && p_acc == p0, "R4 no request", c_acc - c0 + p_acc - p0, 0);
        if (!wr) chk(h_rdata == 32'hFFFF_FFFF, "R4 read ones", h_rdata, 32'hFFFF_FFFF);
      end
      3: begin
        chk(c_acc == c0 + 1, "R10 one config request", c_acc - c0, 1);
        chk(c_done_seen, "R8 wait for done", {31'b0, c_done_seen}, 32'h1);
        if (!wr) chk(h_rdata == last_c_rd, "R8 read data", h_rdata, last_c_rd);
      end
      default: begin
        chk(p_acc == p0 + 1 && c_acc == c0, (a == 16'h0CF8) ? "R3 narrow forwarded" : "R9 forwarded",
            p_acc - p0, 1);
        if (!wr) chk(h_rdata == last_p_rd, "R9 read data", h_rdata, last_p_rd);
      end
    endcase
  endtask

  task automatic idle();
    @(negedge clk);
    h_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    sh_en = 0; sh_bus = 0; sh_dev = 0; sh_func = 0; sh_reg = 0;
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!h_ready && !c_valid && !p_valid && !h_rvalid, "R1 reset outputs",
        {28'b0, h_ready, c_valid, p_valid, h_rvalid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!h_ready && !c_valid && !p_valid, "R1 idle after reset", {29'b0, h_ready, c_valid, p_valid}, 32'h0);
    access(0, 16'h0CF8, 4'hF, 32'h0);
    chk(h_rdata == 32'h0, "R1 selector zero", h_rdata, 32'h0);
    // R2: reserved and type bits dropped
    access(1, 16'h0CF8, 4'hF, 32'h7F2A_5B7F);
    access(0, 16'h0CF8, 4'hF, 32'h0);
    // R4: disabled data port, read and write
    access(0, 16'h0CFC, 4'hF, 32'h0);
    access(1, 16'h0CFC, 4'hF, 32'h1234_5678);
    // R3: narrow selector access goes to pass-through, selector kept
    access(1, 16'h0CF8, 4'h3, 32'hFFFF_FFFF);
    access(0, 16'h0CF8, 4'hF, 32'h0);
    // R5 and R11: local type 0, back-to-back after selector write
    access(1, 16'h0CF8, 4'hF, 32'h8000_F9A4);
    access(0, 16'h0CFC, 4'hF, 32'h0);
    // R7: byte-wide write at CFEh
    access(1, 16'h0CFE, 4'h4, 32'h00AB_0000);
    // R6: remote bus
    access(1, 16'h0CF8, 4'hF, 32'h8007_0810);
    access(0, 16'h0CFD, 4'h2, 32'h0);
    idle();
    local_bus = 8'h07;
    access(0, 16'h0CFC, 4'hF, 32'h0);
    // R9: unrelated port
    access(1, 16'h0080, 4'h1, 32'h0000_00C3);
    access(0, 16'h03F8, 4'hF, 32'h0);
    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 10;
      bit wr = $urandom % 2;
      logic [3:0] be = 4'($urandom % 15 + 1);
      logic [31:0] wd = $urandom;
      if (r == 9) begin
        idle();
        local_bus = ($urandom % 2) ? sh_bus : 8'($urandom);
        continue;
      end
      if (r < 3) begin
        wd[31] = ($urandom % 4 != 0);
        if ($urandom % 2) wd[23:16] = local_bus;
        access(wr, 16'h0CF8, 4'hF, wd);
      end else if (r == 3) begin
        access(wr, 16'h0CF8, (be == 4'hF) ? 4'h7 : be, wd);
      end else if (r < 7) begin
        access(wr, 16'h0CFC + 16'($urandom % 4), be, wd);
      end else begin
        access(wr, 16'($urandom), be, wd);
      end
    end
    idle();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule